// File: doc/BRIEF.md
# Status Register Masked Write Unit

This block holds two 32-bit status words, a current one and a saved one, and applies masked write requests to them. A request selects the target word. It names up to four fields and supplies a source operand. The operand is either a full 32-bit register value or a compact immediate: an 8-bit pattern rotated right by twice a 4-bit rotate field. The block turns the named fields into a bit mask, merges the operand into the target word under that mask, and refuses requests that are not allowed.

The privilege level comes from the mode code held in bits [4:0] of the current word. Mode `5'h10` is the unprivileged user mode and mode `5'h1F` is the system mode. Every other code is privileged and has a saved word. In privileged modes each field select opens one byte. In user mode only the condition flags and the SIMD greater-or-equal bits can change, whatever fields the request names. This stops an unprivileged writer from raising its own privilege.

Instruction decode, condition evaluation and the side effects of a mode change belong to the surrounding core. They are not part of this block.

Top module: `stat_write_unit`

## Requirements
- R1: A synchronous reset sets the current word to `32'h0000_0013` and the saved word to zero, and clears `flagsUpd`.
- R2: In a privileged mode, field select bit k (k = 0..3) enables bits [8k+7:8k], and `writeMask` is the union of the enabled bytes.
- R3: In user mode (`curReg[4:0] == 5'h10`), `reqFields[3]` enables bits [31:27], `reqFields[2]` enables bits [19:16], and `reqFields[1:0]` have no effect. No other bit can be written.
- R4: A committed write sets the target word to `(old & ~writeMask) | (operand & writeMask)`. Bits outside the mask keep their value.
- R5: When `reqUseImm` is 1, the operand is `reqImm` zero-extended to 32 bits and rotated right by `2*reqRot`.
- R6: A request to the saved word while the mode is user or system (`5'h1F`) raises `accessErr` and changes neither word.
- R7: A register-sourced request with `reqSrcIdx == 15` raises `accessErr` and changes neither word. The index is ignored for immediate requests.
- R8: When `reqValid` is low, both words hold their values and `accessErr` is low.
- R9: `flagsUpd` is high for exactly the one cycle after a committed write that changed any of current-word bits [31:27]. It is low otherwise.
- R10: A privileged write to field 0 of the current word can change the mode. The new mode governs the mask and the error checks from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Write request strobe |
| reqTargetSaved | input | 1 | 1 targets the saved word, 0 the current word |
| reqFields | input | 4 | Field selects (byte k, or the user-mode groups) |
| reqUseImm | input | 1 | 1 takes the rotated immediate as operand |
| reqRegVal | input | 32 | Register operand value |
| reqSrcIdx | input | 4 | Index of the source register |
| reqImm | input | 8 | Immediate pattern |
| reqRot | input | 4 | Immediate rotate field (amount is twice this) |
| writeMask | output | 32 | Effective write mask for the present request |
| accessErr | output | 1 | Request is illegal; no write takes place |
| curReg | output | 32 | Current status word |
| savReg | output | 32 | Saved status word |
| flagsUpd | output | 1 | Flag bits [31:27] changed on the last write |

## Verification
The assertions assume that `rst` is held high from time zero through the first clock edge, and that the request inputs are stable around each rising edge. The bench drives every request on the falling edge and holds `reqValid` low throughout reset, so both assumptions are met. Random requests can move the mode into user mode, where nothing can move it back. The bench therefore reapplies reset at fixed intervals, so that each stretch covers privileged, system and user behaviour.

// File: rtl/swu_pkg.sv
package swu_pkg;
  localparam int REG_W = 32;
  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] MODE_USER  = 5'h10;
  localparam logic [MODE_W-1:0] MODE_SYS   = 5'h1F;
  localparam logic [MODE_W-1:0] MODE_RESET = 5'h13;

  typedef struct packed {
    logic wrCur;
    logic wrSav;
  } swuStrobe_t;
endpackage

// File: rtl/swu_ctrl.sv
module swu_ctrl
  import swu_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  parameter int FLD_N  = 4
) (
  input  logic                  reqValid,
  input  logic                  reqTargetSaved,
  input  logic [FLD_N-1:0]      reqFields,
  input  logic                  reqUseImm,
  input  logic [IDX_W-1:0]      reqSrcIdx,
  input  logic [MODE_W-1:0]     curMode,
  output swuStrobe_t            strobe,
  output logic [REG_W-1:0]      writeMask,
  output logic                  accessErr
);
  localparam int BYTE_W = REG_W / FLD_N;

  logic [REG_W-1:0] privMask;
  logic [REG_W-1:0] userMask;
  logic isUser, isSys, savedBad, pcBad;

  for (genvar b = 0; b < FLD_N; b++) begin : g_byte
    assign privMask[b*BYTE_W +: BYTE_W] = {BYTE_W{reqFields[b]}};
  end

  always_comb begin
    userMask        = '0;
    userMask[31:27] = {5{reqFields[3]}};
    userMask[19:16] = {4{reqFields[2]}};
  end

  always_comb begin
    isUser    = (curMode == MODE_USER);
    isSys     = (curMode == MODE_SYS);
    writeMask = isUser ? userMask : privMask;
    savedBad  = reqTargetSaved && (isUser || isSys);
    pcBad     = !reqUseImm && (reqSrcIdx == IDX_W'(PC_IDX));
    accessErr = reqValid && (savedBad || pcBad);
    strobe.wrCur = reqValid && !accessErr && !reqTargetSaved;
    strobe.wrSav = reqValid && !accessErr && reqTargetSaved;
  end
endmodule

// File: rtl/swu_datapath.sv
module swu_datapath
  import swu_pkg::*;
#(
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  swuStrobe_t        strobe,
  input  logic [REG_W-1:0]  writeMask,
  input  logic              reqUseImm,
  input  logic [REG_W-1:0]  reqRegVal,
  input  logic [IMM_W-1:0]  reqImm,
  input  logic [ROT_W-1:0]  reqRot,
  output logic [REG_W-1:0]  curReg,
  output logic [REG_W-1:0]  savReg,
  output logic              flagsUpd
);
  localparam int AMT_W = $clog2(REG_W) + 1;

  logic [AMT_W-1:0] rotAmt;
  logic [REG_W-1:0] immWide, immRot, operand, curNext, savNext;

  always_comb begin
    rotAmt  = AMT_W'({reqRot, 1'b0});
    immWide = REG_W'(reqImm);
    immRot  = (immWide >> rotAmt) | (immWide << (AMT_W'(REG_W) - rotAmt));
    operand = reqUseImm ? immRot : reqRegVal;
    curNext = (curReg & ~writeMask) | (operand & writeMask);
    savNext = (savReg & ~writeMask) | (operand & writeMask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curReg   <= REG_W'(MODE_RESET);
      savReg   <= '0;
      flagsUpd <= 1'b0;
    end else begin
      flagsUpd <= strobe.wrCur && (curNext[31:27] != curReg[31:27]);
      if (strobe.wrCur) curReg <= curNext;
      if (strobe.wrSav) savReg <= savNext;
    end
  end
endmodule

// File: rtl/stat_write_unit.sv
module stat_write_unit
  import swu_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  parameter int FLD_N  = 4,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqTargetSaved,
  input  logic [FLD_N-1:0] reqFields,
  input  logic             reqUseImm,
  input  logic [31:0]      reqRegVal,
  input  logic [IDX_W-1:0] reqSrcIdx,
  input  logic [IMM_W-1:0] reqImm,
  input  logic [ROT_W-1:0] reqRot,
  output logic [31:0]      writeMask,
  output logic             accessErr,
  output logic [31:0]      curReg,
  output logic [31:0]      savReg,
  output logic             flagsUpd
);
  swuStrobe_t strobe;

  swu_ctrl #(.IDX_W(IDX_W), .PC_IDX(PC_IDX), .FLD_N(FLD_N)) u_ctrl (
    .reqValid(reqValid), .reqTargetSaved(reqTargetSaved), .reqFields(reqFields),
    .reqUseImm(reqUseImm), .reqSrcIdx(reqSrcIdx), .curMode(curReg[MODE_W-1:0]),
    .strobe(strobe), .writeMask(writeMask), .accessErr(accessErr)
  );

  swu_datapath #(.IMM_W(IMM_W), .ROT_W(ROT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .writeMask(writeMask),
    .reqUseImm(reqUseImm), .reqRegVal(reqRegVal), .reqImm(reqImm), .reqRot(reqRot),
    .curReg(curReg), .savReg(savReg), .flagsUpd(flagsUpd)
  );
endmodule

// File: rtl/stat_write_unit_chk.sv
module stat_write_unit_chk
  import swu_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic        reqTargetSaved,
  input logic        accessErr,
  input logic [31:0] writeMask,
  input logic [31:0] curReg,
  input logic [31:0] savReg,
  input logic        flagsUpd
);
  AST_USER_MASK_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (curReg[4:0] == MODE_USER) |-> ((writeMask & ~32'hF80F_0000) == 32'h0)); // R3
  AST_SAVED_MODE_ERR: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqTargetSaved && (curReg[4:0] == MODE_USER || curReg[4:0] == MODE_SYS))
      |-> accessErr); // R6
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    accessErr |=> ($stable(curReg) && $stable(savReg))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> ($stable(curReg) && $stable(savReg))); // R8
  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> !accessErr); // R8
  AST_OUTSIDE_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqTargetSaved) |=> (((curReg ^ $past(curReg)) & ~$past(writeMask)) == 32'h0)); // R4
  AST_FLAGS_PULSE_REAL: assert property (@(posedge clk) disable iff (rst)
    flagsUpd |-> (curReg[31:27] != $past(curReg[31:27]))); // R9
endmodule

bind stat_write_unit stat_write_unit_chk u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqTargetSaved(reqTargetSaved),
  .accessErr(accessErr), .writeMask(writeMask), .curReg(curReg), .savReg(savReg),
  .flagsUpd(flagsUpd)
);

// File: tb/sim_stat_write_unit.sv
module sim_stat_write_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqTargetSaved = 1'b0, reqUseImm = 1'b0;
  logic [3:0] reqFields = '0, reqSrcIdx = '0, reqRot = '0;
  logic [31:0] reqRegVal = '0;
  logic [7:0] reqImm = '0;
  logic [31:0] writeMask, curReg, savReg;
  logic accessErr, flagsUpd;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mCur, mSav;

  always #5 clk = ~clk;

  stat_write_unit u0 (.*);

  function automatic logic [31:0] expMask(input logic [3:0] f, input logic [4:0] mode);
    logic [31:0] m = '0;
    if (mode == 5'h10) begin
      if (f[3]) m[31:27] = '1;
      if (f[2]) m[19:16] = '1;
    end else begin
      for (int b = 0; b < 4; b++) if (f[b]) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

  function automatic logic [31:0] expImm(input logic [7:0] v, input logic [3:0] r);
    logic [31:0] w = {24'h0, v};
    for (int i = 0; i < 2*r; i++) w = {w[0], w[31:1]};
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1; reqValid = 0;
    @(negedge clk); @(negedge clk); rst = 0;
    mCur = 32'h0000_0013; mSav = 0;
    chk("R1 cur", curReg, mCur);
    chk("R1 sav", savReg, mSav);
    chk("R1 flagsUpd", {31'h0, flagsUpd}, 32'h0);
  endtask

  task automatic doReq(input logic v, input logic sv, input logic [3:0] f,
                       input logic ui, input logic [31:0] rv, input logic [3:0] idx,
                       input logic [7:0] im, input logic [3:0] rt);
    logic [31:0] m, op, nCur;
    logic err, fl;
    @(negedge clk);
    reqValid = v; reqTargetSaved = sv; reqFields = f; reqUseImm = ui;
    reqRegVal = rv; reqSrcIdx = idx; reqImm = im; reqRot = rt;
    #1;
    m   = expMask(f, mCur[4:0]);
    err = v && ((sv && (mCur[4:0] == 5'h10 || mCur[4:0] == 5'h1F)) || (!ui && idx == 4'd15));
    chk(mCur[4:0] == 5'h10 ? "R3 mask" : "R2 mask", writeMask, m);
    chk(sv ? "R6 err" : (v ? "R7 err" : "R8 err"), {31'h0, accessErr}, {31'h0, err});
    op = ui ? expImm(im, rt) : rv;
    fl = 0;
    if (v && !err) begin
      if (sv) mSav = (mSav & ~m) | (op & m);
      else begin
        nCur = (mCur & ~m) | (op & m);
        fl = (nCur[31:27] != mCur[31:27]);
        mCur = nCur;
      end
    end
    @(posedge clk); #1;
    chk(ui ? "R5 cur" : (v ? "R4 cur" : "R8 cur"), curReg, mCur);
    chk(err ? "R6/R7 sav" : "R4 sav", savReg, mSav);
    chk("R9 flagsUpd", {31'h0, flagsUpd}, {31'h0, fl});
    reqValid = 0;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    doReset();
    // R4 privileged flags byte from register
    doReq(1, 0, 4'b1000, 0, 32'hA500_0000, 4'd3, 0, 0);
    // R9 same value again: no flag pulse
    doReq(1, 0, 4'b1000, 0, 32'hA500_0000, 4'd3, 0, 0);
    // R5 immediate rotate
    doReq(1, 0, 4'b0100, 1, 0, 4'd15, 8'hFF, 4'd9);
    doReq(1, 0, 4'b1111, 1, 0, 4'd15, 8'hF3, 4'd1);
    // R7 program counter index
    doReq(1, 0, 4'b1111, 0, 32'hFFFF_FFFF, 4'd15, 0, 0);
    // R2 saved word in privileged mode, union of two bytes
    doReq(1, 1, 4'b1010, 0, 32'h1234_5678, 4'd2, 0, 0);
    // R8 idle
    doReq(0, 0, 4'b1111, 0, 32'hFFFF_FFFF, 4'd1, 0, 0);
    // R10 switch to system mode, then saved access fails (R6)
    doReq(1, 0, 4'b0001, 1, 0, 4'd0, 8'h1F, 4'd0);
    doReq(1, 1, 4'b1111, 0, 32'hDEAD_BEEF, 4'd1, 0, 0);
    // R10 switch to user mode, then R3 restriction and R6
    doReq(1, 0, 4'b0001, 1, 0, 4'd0, 8'h10, 4'd0);
    doReq(1, 0, 4'b1111, 0, 32'hFFFF_FFFF, 4'd4, 0, 0);
    doReq(1, 0, 4'b0011, 0, 32'h0000_0000, 4'd4, 0, 0);
    doReq(1, 1, 4'b1000, 0, 32'h0, 4'd4, 0, 0);
    for (int i = 0; i < 600; i++) begin
      if (i % 60 == 0) doReset();
      doReq(($urandom % 8) != 0, ($urandom % 4) == 0, 4'($urandom), ($urandom % 2) == 1,
            $urandom, 4'($urandom), 8'($urandom), 4'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule